// File: doc/BRIEF.md
# Serial Audio Transmitter with Selectable Framing

This block sends stereo two's-complement samples, 24 bits each, one bit at a time on a serial data line. A bit clock and a word clock frame the data: the word clock marks which channel is on the line, and the bit clock marks each bit. A 2-bit format code picks the framing. Codes 00, 01 and 10 give MSB-justified framing. Code 11 gives I2S-compatible framing. The block can make both clocks itself from the system clock (master), or it can follow clocks that come in from outside (slave).

Samples arrive as a left/right pair with a valid/ready handshake. The block takes a new pair at the start of every left slot and holds the last pair if none is offered. With a bit clock of 32 per frame, each slot carries only the top 16 bits of its sample. With 64 per frame, each slot carries the full word and the unused positions are zero.

A small state machine tracks the slot. `ST_SYNC` is the state after reset, before any word-clock change has been seen. The first change moves it to `ST_LEFT` or `ST_RIGHT`, depending on the new word-clock level. After that, each word-clock change moves it from `ST_LEFT` to `ST_RIGHT` or from `ST_RIGHT` to `ST_LEFT`. Each change also restarts the bit position count at zero.

Top module: `aud_ser_tx`

## Requirements
- R1: Each sample is sent most significant bit first, as two's complement, and the bits of one slot rebuild the sample word.
- R2: Format codes 00, 01 and 10 are MSB-justified. The left channel is sent while the word clock is high, and sample bit 23 is on the line during the first bit-clock period of the slot.
- R3: Format code 11 is I2S. The left channel is sent while the word clock is low, and bit 23 appears one bit-clock period after the word-clock edge. At 32fs, the last sent bit (bit 8) falls in position 0 of the next slot.
- R4: The serial data changes only after a falling bit-clock edge. It is stable while the bit clock is high.
- R5: With `fs32` = 1 (32 bit clocks per frame), only bits 23 down to 8 of each sample are sent.
- R6: Slot positions after the last data bit are driven low.
- R7: In master mode, the bit clock period is 2*HALF_DIV system clocks. The word clock changes only on a falling bit-clock edge. Each slot is 32 bit-clock periods long (16 when `fs32` = 1).
- R8: In slave mode (`master` = 0), the clocks come from `bclk_i`/`wclk_i`, and `bclk_o`/`wclk_o` stay low.
- R9: `smp_ready` is a one-cycle pulse, once per frame, at the start of each left slot. The pair is taken in that cycle if `smp_valid` is high.
- R10: If `smp_valid` is low when `smp_ready` pulses, the previous pair is sent again.
- R11: During reset, `sdata_o`, `bclk_o`, `wclk_o` and `smp_ready` are low, and the held pair is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt | input | 2 | Framing code: 11 = I2S, others = MSB-justified |
| master | input | 1 | 1 = generate clocks, 0 = follow external clocks |
| fs32 | input | 1 | 1 = 32 bit clocks per frame (truncate), 0 = 64 |
| smp_left | input | 24 | Left sample |
| smp_right | input | 24 | Right sample |
| smp_valid | input | 1 | Sample pair offered |
| smp_ready | output | 1 | Pair taken this cycle when valid |
| bclk_i | input | 1 | External bit clock (slave) |
| wclk_i | input | 1 | External word clock (slave) |
| bclk_o | output | 1 | Generated bit clock (master) |
| wclk_o | output | 1 | Generated word clock (master) |
| sdata_o | output | 1 | Serial data |

## Verification
The hardest case to reach is the I2S slot boundary at 32fs. There, the last bit of one channel goes out in position 0 of the other channel's slot, so a fault shows only when two neighbouring words differ in bit 8. The bench sends alternating corner words (0x800000, 0x7FFFFF, all ones, 0x000001) and varied values, in both master and slave mode. It withholds `smp_valid` in every third frame, so that held pairs and the spill bit meet at the same boundary.

// File: rtl/aud_ser_tx_pkg.sv
package aud_ser_tx_pkg;

    typedef enum logic [1:0] {
        FMT_MJ_0 = 2'b00,
        FMT_MJ_1 = 2'b01,
        FMT_MJ_2 = 2'b10,
        FMT_I2S  = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        ST_SYNC  = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2
    } slot_st_e;

endpackage

// File: rtl/aud_ser_tx_clkgen.sv
module aud_ser_tx_clkgen #(
    parameter int HALF_DIV   = 4,
    parameter int FRAME_BITS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic i2s,
    input  logic fs32,
    output logic bclk_o,
    output logic wclk_o,
    output logic tick_o
);
    localparam int DVW   = $clog2(HALF_DIV + 1);
    localparam int CW    = $clog2(FRAME_BITS);
    localparam int SHORT = FRAME_BITS / 2;

    logic [DVW-1:0] div_q;
    logic [CW-1:0]  bit_q, bit_nx, last_bit, half_bits;
    logic           bclk_q, wclk_q, tick_q;

    always_comb begin
        last_bit  = fs32 ? CW'(SHORT - 1) : CW'(FRAME_BITS - 1);
        half_bits = fs32 ? CW'(SHORT / 2) : CW'(FRAME_BITS / 2);
        bit_nx    = (bit_q >= last_bit) ? '0 : bit_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            div_q  <= '0;
            bclk_q <= 1'b0;
            wclk_q <= 1'b0;
            tick_q <= 1'b0;
            bit_q  <= '1;
        end else begin
            tick_q <= 1'b0;
            if (div_q == DVW'(HALF_DIV - 1)) begin
                div_q  <= '0;
                bclk_q <= ~bclk_q;
                if (bclk_q) begin
                    bit_q  <= bit_nx;
                    wclk_q <= (bit_nx < half_bits) ^ i2s;
                    tick_q <= 1'b1;
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign bclk_o = bclk_q;
    assign wclk_o = wclk_q;
    assign tick_o = tick_q;

    // R7: word clock moves only together with a falling bit clock
    assert_wclk_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n || !en)
        (wclk_q != $past(wclk_q)) |-> ($past(bclk_q) && !bclk_q));

    // R7: slot strobe is raised only in the low phase of the bit clock
    assert_tick_low_phase_R7: assert property (@(posedge clk) disable iff (!rst_n || !en)
        tick_q |-> !bclk_q);

endmodule

// File: rtl/aud_ser_tx_insync.sv
module aud_ser_tx_insync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic wclk_i,
    output logic tick_o,
    output logic wc_o
);
    logic [STAGES-1:0] b_sh, w_sh;
    logic              b_last, tick_q, wc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_sh   <= '0;
            w_sh   <= '0;
            b_last <= 1'b0;
            tick_q <= 1'b0;
            wc_q   <= 1'b0;
        end else begin
            b_sh   <= {b_sh[STAGES-2:0], bclk_i};
            w_sh   <= {w_sh[STAGES-2:0], wclk_i};
            b_last <= b_sh[STAGES-1];
            tick_q <= b_last & ~b_sh[STAGES-1];
            wc_q   <= w_sh[STAGES-1];
        end
    end

    assign tick_o = tick_q;
    assign wc_o   = wc_q;

    // R8: one strobe per falling external bit clock, never two in a row
    assert_single_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |=> !tick_q);

endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx #(
    parameter int DW          = 24,
    parameter int TW          = 16,
    parameter int HALF_DIV    = 4,
    parameter int FRAME_BITS  = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    fmt,
    input  logic          master,
    input  logic          fs32,
    input  logic [DW-1:0] smp_left,
    input  logic [DW-1:0] smp_right,
    input  logic          smp_valid,
    output logic          smp_ready,
    input  logic          bclk_i,
    input  logic          wclk_i,
    output logic          bclk_o,
    output logic          wclk_o,
    output logic          sdata_o
);
    import aud_ser_tx_pkg::*;

    localparam int PW = $clog2(DW) + 2;
    localparam logic [DW-1:0] TMASK = {{TW{1'b1}}, {(DW-TW){1'b0}}};

    logic          m_tick, m_wc, s_tick, s_wc, tick, wc;
    logic          i2s, left_lvl, slot_start, into_left;
    slot_st_e      state_q, state_nx;
    logic [DW-1:0] held_l, held_r, sh_q, raw_word, word;
    logic [PW-1:0] pos_q;
    logic          prev_wc, sdata_q;

    aud_ser_tx_clkgen #(
        .HALF_DIV   (HALF_DIV),
        .FRAME_BITS (FRAME_BITS)
    ) u_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (master),
        .i2s    (i2s),
        .fs32   (fs32),
        .bclk_o (bclk_o),
        .wclk_o (m_wc),
        .tick_o (m_tick)
    );

    aud_ser_tx_insync #(
        .STAGES (SYNC_STAGES)
    ) u_insync (
        .clk    (clk),
        .rst_n  (rst_n),
        .bclk_i (bclk_i),
        .wclk_i (wclk_i),
        .tick_o (s_tick),
        .wc_o   (s_wc)
    );

    assign wclk_o = m_wc;

    always_comb begin
        i2s        = (fmt == FMT_I2S);
        left_lvl   = ~i2s;
        tick       = master ? m_tick : s_tick;
        wc         = master ? m_wc : s_wc;
        slot_start = tick && (wc != prev_wc);
        into_left  = slot_start && (wc == left_lvl);
        raw_word   = into_left ? (smp_valid ? smp_left : held_l) : held_r;
        word       = fs32 ? (raw_word & TMASK) : raw_word;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_SYNC:  if (slot_start) state_nx = into_left ? ST_LEFT : ST_RIGHT;
            ST_LEFT:  if (slot_start) state_nx = ST_RIGHT;
            ST_RIGHT: if (slot_start) state_nx = ST_LEFT;
            default:  state_nx = ST_SYNC;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SYNC;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_l  <= '0;
            held_r  <= '0;
            sh_q    <= '0;
            pos_q   <= '0;
            prev_wc <= 1'b0;
            sdata_q <= 1'b0;
        end else begin
            if (tick) prev_wc <= wc;
            if (slot_start) begin
                pos_q <= '0;
                if (into_left && smp_valid) begin
                    held_l <= smp_left;
                    held_r <= smp_right;
                end
                if (i2s) begin
                    sdata_q <= sh_q[DW-1];
                    sh_q    <= word;
                end else begin
                    sdata_q <= word[DW-1];
                    sh_q    <= {word[DW-2:0], 1'b0};
                end
            end else if (tick) begin
                if (pos_q != '1) pos_q <= pos_q + 1'b1;
                if (state_q == ST_SYNC) begin
                    sdata_q <= 1'b0;
                end else begin
                    sdata_q <= sh_q[DW-1];
                    sh_q    <= {sh_q[DW-2:0], 1'b0};
                end
            end
        end
    end

    assign smp_ready = into_left;
    assign sdata_o   = sdata_q;

    // R4: data moves only in the cycle after a falling-edge strobe
    assert_data_after_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata_q) |-> $past(tick));

    // R6: positions past the last data bit are low
    assert_trailing_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !slot_start && state_q != ST_SYNC && pos_q >= PW'(DW)) |=> !sdata_q);

    // R9: ready is a single-cycle pulse
    assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready |=> !smp_ready);

    // R10: the held pair changes only on an accepted handshake
    assert_hold_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(smp_ready && smp_valid) |=> ($stable(held_l) && $stable(held_r)));

    // R8: generated clock pins stay low in slave mode
    assert_slave_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !master |-> (!bclk_o && !wclk_o));

endmodule

// File: tb/aud_ser_tx_bench.sv
module aud_ser_tx_bench;
    localparam int HALF = 4;
    localparam int SH   = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt = 2'b00;
    logic        master = 1'b1, fs32 = 1'b0;
    logic [23:0] smp_left = '0, smp_right = '0;
    logic        smp_valid = 1'b1;
    logic        smp_ready;
    logic        bclk_drv = 1'b0, wclk_drv = 1'b0;
    logic        bclk_o, wclk_o, sdata_o;

    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    aud_ser_tx u_aud_ser_tx (
        .clk(clk), .rst_n(rst_n), .fmt(fmt), .master(master), .fs32(fs32),
        .smp_left(smp_left), .smp_right(smp_right), .smp_valid(smp_valid),
        .smp_ready(smp_ready), .bclk_i(bclk_drv), .wclk_i(wclk_drv),
        .bclk_o(bclk_o), .wclk_o(wclk_o), .sdata_o(sdata_o)
    );

    wire bclk_obs = master ? bclk_o : bclk_drv;
    wire wclk_obs = master ? wclk_o : wclk_drv;
    wire i2s_cfg  = (fmt == 2'b11);

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [23:0] pat(input int k);
        case (k % 6)
            0: return 24'h800000;
            1: return 24'h7FFFFF;
            2: return 24'hFFFFFF;
            3: return 24'h000001;
            default: return 24'(k * 32'h002B5A37 + 32'h135);
        endcase
    endfunction

    function automatic logic exp_bit(input int p, input logic fi2s, input logic f32,
                                     input logic [23:0] wd, input logic [23:0] pw);
        int idx;
        int lo;
        lo = f32 ? 8 : 0;
        if (!fi2s) idx = 23 - p;
        else if (p == 0) return f32 ? pw[8] : 1'b0;
        else idx = 24 - p;
        if (idx >= lo && idx <= 23) return wd[idx];
        return 1'b0;
    endfunction

    // port-level model, sampled on the falling system clock
    logic        b_prev, w_prev, wr_prev, armed, have_rise, pend, hold_flag, slot_held;
    logic        rise_sd, hi_sd, lft;
    logic [23:0] cur_l, cur_r, slotword, prevword, recv;
    int          p, lcount, gen, clk_since, ready_cnt;

    always @(negedge clk) begin
        if (!rst_n) begin
            b_prev = 0; w_prev = 0; wr_prev = 0; armed = 0; have_rise = 0;
            pend = 0; hold_flag = 0; slot_held = 0; rise_sd = 0; hi_sd = 0;
            cur_l = '0; cur_r = '0; slotword = '0; prevword = '0; recv = '0;
            p = 0; lcount = 0; gen = 0; clk_since = 0; ready_cnt = 0;
            smp_valid = 1'b1; smp_left = pat(0); smp_right = pat(7);
        end else begin
            logic b, w, sd, e;
            string tag;
            int n;
            b = bclk_obs; w = wclk_obs; sd = sdata_o;
            clk_since++;
            if (pend) begin
                gen++;
                smp_left = pat(gen); smp_right = pat(gen + 7);
                pend = 0;
            end
            if (smp_ready) begin
                ready_cnt++;
                if (smp_valid) begin cur_l = smp_left; cur_r = smp_right; pend = 1; end
                else hold_flag = 1;
            end
            if (master && w != w_prev) chk(b_prev && !b, "R7 wclk edge", {31'b0, b}, 32'h0);
            if (b && !b_prev) begin
                if (master) begin
                    if (have_rise) chk(clk_since == 2*HALF, "R7 bclk period", clk_since, 2*HALF);
                    have_rise = 1;
                end else begin
                    chk(!bclk_o && !wclk_o, "R8 slave pins", {30'b0, bclk_o, wclk_o}, 32'h0);
                end
                clk_since = 0;
                n = fs32 ? 16 : 24;
                if (w != wr_prev) begin
                    if (i2s_cfg && fs32) recv = {recv[22:0], sd};
                    if (armed) begin
                        chk(recv == (fs32 ? {8'b0, prevword[23:8] & 16'hFFFF} : slotword) ||
                            recv == (fs32 ? {8'b0, slotword[23:8]} : slotword),
                            fs32 ? "R5 slot word" : "R1 slot word", recv,
                            fs32 ? {8'b0, slotword[23:8]} : slotword);
                        if (master) chk(p + 1 == (fs32 ? 16 : 32), "R7 slot length", p + 1, fs32 ? 16 : 32);
                    end
                    lft = (w == ~i2s_cfg);
                    if (lft) begin
                        if (armed) chk(ready_cnt == 1, "R9 ready per frame", ready_cnt, 1);
                        ready_cnt = 0;
                        armed = 1;
                        slot_held = hold_flag; hold_flag = 0;
                        lcount++;
                        smp_valid = ((lcount % 3) != 1);
                    end
                    prevword = slotword;
                    slotword = lft ? cur_l : cur_r;
                    p = 0; recv = '0;
                end else if (p < 63) begin
                    p++;
                end
                wr_prev = w;
                if (armed) begin
                    e = exp_bit(p, i2s_cfg, fs32, slotword, prevword);
                    if (slot_held) tag = "R10 held pair";
                    else if ((!i2s_cfg && p >= 24) || (i2s_cfg && p >= 25)) tag = "R6 trailing";
                    else if (fs32) tag = "R5 bit";
                    else if (i2s_cfg) tag = "R3 bit";
                    else tag = "R2 bit";
                    chk(sd == e, tag, {31'b0, sd}, {31'b0, e});
                end
                if ((!i2s_cfg && p < n) || (i2s_cfg && p >= 1 && p <= (fs32 ? 15 : 24)))
                    recv = {recv[22:0], sd};
                rise_sd = sd;
            end
            if (!b && b_prev && armed) chk(hi_sd == rise_sd, "R4 stable high", {31'b0, hi_sd}, {31'b0, rise_sd});
            if (b) hi_sd = sd;
            b_prev = b; w_prev = w;
        end
    end

    task automatic slave_frames(input int frames);
        int slen;
        slen = fs32 ? 16 : 32;
        bclk_drv = 1'b1;
        repeat (SH) @(posedge clk);
        #1;
        for (int f = 0; f < frames; f++) begin
            for (int k = 0; k < 2*slen; k++) begin
                bclk_drv = 1'b0;
                wclk_drv = (k < slen) ^ i2s_cfg;
                repeat (SH) @(posedge clk);
                #1;
                bclk_drv = 1'b1;
                repeat (SH) @(posedge clk);
                #1;
            end
        end
    endtask

    task automatic run_cfg(input logic m, input logic [1:0] f, input logic s);
        @(posedge clk); #1;
        rst_n = 1'b0; master = m; fmt = f; fs32 = s; bclk_drv = 1'b0; wclk_drv = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        chk(!sdata_o && !bclk_o && !wclk_o && !smp_ready, "R11 reset outputs",
            {28'b0, sdata_o, bclk_o, wclk_o, smp_ready}, 32'h0);
        rst_n = 1'b1;
        if (m) begin
            while (lcount < 9) @(posedge clk);
            #1;
        end else begin
            slave_frames(9);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        run_cfg(1'b1, 2'b00, 1'b0);
        run_cfg(1'b1, 2'b01, 1'b0);
        run_cfg(1'b1, 2'b10, 1'b0);
        run_cfg(1'b1, 2'b11, 1'b0);
        run_cfg(1'b1, 2'b01, 1'b1);
        run_cfg(1'b1, 2'b11, 1'b1);
        run_cfg(1'b0, 2'b00, 1'b0);
        run_cfg(1'b0, 2'b11, 1'b0);
        run_cfg(1'b0, 2'b01, 1'b1);
        run_cfg(1'b0, 2'b11, 1'b1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule